// File: doc/BRIEF.md
# UART Status Message Sequencer

This block sits in front of a byte-wide UART transmitter. It turns single-cycle event requests into complete ASCII text lines, so that a design's status can be read on a serial terminal. The UART's serializer, baud generator and receive path are separate. This block drives only the UART's control-register port and its transmit-load port.

After reset the block puts the UART into reset. It then runs a fixed setup: it drives a first control value, strobes the control-register load, and then drives a second control value. Only after that does it wait for requests. Each request line selects one stored message. The message is fed to the transmitter one byte at a time. Each byte is placed on the data bus one cycle before its load strobe, and a new byte is placed only while the transmitter reports ready. Every message ends with a carriage return and a line feed. A zero terminator closes the message and is never sent.

Requests that arrive while a message is being sent are remembered and are served afterwards, lowest request index first.

Top module: `status_msg_seq`

## Requirements
- R1: While reset is active and during the first cycle after the synchronised reset release, `uart_rst_o` is 1, `tx_load_o` and `ctrl_ld_o` are 0, and `busy_o` is 0.
- R2: When `uart_rst_o` falls, setup follows on consecutive cycles:
  - one cycle with `ctrl_data_o`=CFG_A and `ctrl_ld_o`=0;
  - one cycle with `ctrl_data_o`=CFG_A and `ctrl_ld_o`=1;
  - `ctrl_data_o` then moves to CFG_B and stays there, with `ctrl_ld_o`=0;
  - the block then idles.
- R3: Request bit k selects message k. The texts are: 0 = "PASS", 1 = "RESET", 2 = "FAIL", 3 = empty text. The bytes of the text appear on `tx_data_o` in string order, one per `tx_load_o` pulse.
- R4: On every cycle with `tx_load_o`=1, `tx_data_o` already held the same value in the previous cycle.
- R5: `tx_load_o` is never high in two consecutive cycles.
- R6: Every message is followed by 0x0D and then 0x0A. The 0x00 terminator is never loaded. An empty text therefore sends only 0x0D, 0x0A.
- R7: A load is issued only if `tx_ready_i` was 1 in the cycle before the load. While `tx_ready_i` stays low, no further load is issued.
- R8: If several request bits are high together, or several are latched, the lowest index is served first. A request pulse that arrives while a message is in progress is latched and served after that message.
- R9: `done_o` is a one-cycle pulse in the cycle after the last 0x0A load. `busy_o` is 1 from the cycle after a request is accepted through the `done_o` cycle, and 0 in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 4 | Message request pulses, one bit per message |
| tx_ready_i | input | 1 | Transmitter can accept a byte |
| uart_rst_o | output | 1 | Reset toward the UART |
| ctrl_data_o | output | 8 | Control-register value toward the UART |
| ctrl_ld_o | output | 1 | Control-register load strobe |
| tx_data_o | output | 8 | Transmit byte |
| tx_load_o | output | 1 | Transmit load strobe |
| busy_o | output | 1 | Message in progress |
| done_o | output | 1 | One-cycle end-of-message pulse |

## Verification
A wrong byte index or message ID in the sequencer shows at the very next load strobe as a mismatched character, or as a missing or extra CR/LF pair. The scoreboard compares each load against the expected string, so such an error is caught on that byte. A wrong state transition shows within one or two cycles in one of three ways: a strobe in the same cycle as a data change, two strobes in a row, or a load while the transmitter is stalled. A lost or misordered latched request shows as a `done_o` marker arriving where the scoreboard expects a character, or as a whole message in the wrong order.

// File: rtl/status_msg_pkg.sv
package status_msg_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MSG_NUM = 4;
  localparam int unsigned ID_W    = $clog2(MSG_NUM);
  localparam int unsigned TXT_MAX = 8;
  localparam int unsigned IDX_W   = $clog2(TXT_MAX + 3);
  localparam logic [BYTE_W-1:0] CH_CR = 8'h0D;
  localparam logic [BYTE_W-1:0] CH_LF = 8'h0A;

  typedef enum logic [2:0] {
    ST_URST, ST_CFG_A, ST_CFG_LD, ST_CFG_B,
    ST_IDLE, ST_FETCH, ST_PUT, ST_LOAD
  } seq_state_t;

  // Byte idx of message id: text, then CR, LF, then zero terminator.
  function automatic logic [BYTE_W-1:0] msg_byte(input logic [ID_W-1:0] id,
                                                 input logic [IDX_W-1:0] idx);
    logic [8*TXT_MAX-1:0] txt;
    logic [8*TXT_MAX-1:0] sh;
    int len;
    case (id)
      2'd0:    begin txt = {"PASS",  32'h0}; len = 4; end
      2'd1:    begin txt = {"RESET", 24'h0}; len = 5; end
      2'd2:    begin txt = {"FAIL",  32'h0}; len = 4; end
      default: begin txt = '0;               len = 0; end
    endcase
    sh = txt << (8 * int'(idx));
    if (int'(idx) < len)            return sh[8*TXT_MAX-1 -: 8];
    else if (int'(idx) == len)      return CH_CR;
    else if (int'(idx) == len + 1)  return CH_LF;
    else                            return '0;
  endfunction

endpackage

// File: rtl/status_rst_sync.sv
module status_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/status_req_arb.sv
module status_req_arb #(
  parameter int unsigned NUM = 4,
  localparam int unsigned IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NUM-1:0] req_i,
  input  logic          take_i,
  output logic          any_o,
  output logic [IW-1:0] id_o
);
  logic [NUM-1:0] pend_q, pend_d, cand, grant;

  assign cand  = pend_q | req_i;
  assign grant = cand & (~cand + 1'b1);
  assign any_o = |cand;

  always_comb begin
    id_o = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (grant[i]) id_o = IW'(i);
    end
  end

  always_comb begin
    pend_d = cand;
    if (take_i) pend_d = cand & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R8: a request not taken stays visible the next cycle
  a_r8_request_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && (|req_i)) |=> any_o);
endmodule

// File: rtl/status_msg_rom.sv
module status_msg_rom
  import status_msg_pkg::*;
(
  input  logic [ID_W-1:0]   id_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  assign byte_o = msg_byte(id_i, idx_i);
endmodule

// File: rtl/status_msg_seq.sv
module status_msg_seq
  import status_msg_pkg::*;
#(
  parameter logic [7:0]  CFG_A      = 8'h36,
  parameter logic [7:0]  CFG_B      = 8'h03,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   req_i,
  input  logic         tx_ready_i,
  output logic         uart_rst_o,
  output logic [7:0]   ctrl_data_o,
  output logic         ctrl_ld_o,
  output logic [7:0]   tx_data_o,
  output logic         tx_load_o,
  output logic         busy_o,
  output logic         done_o
);
  logic rst_s;
  seq_state_t state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [ID_W-1:0]   id_q, arb_id;
  logic              id_en;
  logic [BYTE_W-1:0] data_q, cur_byte;
  logic              data_en;
  logic              arb_any, take;

  status_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  status_req_arb #(.NUM(MSG_NUM)) i_arb (
    .clk(clk), .rst_n(rst_s), .req_i(req_i), .take_i(take),
    .any_o(arb_any), .id_o(arb_id));

  status_msg_rom i_rom (.id_i(id_q), .idx_i(idx_q), .byte_o(cur_byte));

  // next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    id_en   = 1'b0;
    data_en = 1'b0;
    take    = 1'b0;
    case (state_q)
      ST_URST:   state_d = ST_CFG_A;
      ST_CFG_A:  state_d = ST_CFG_LD;
      ST_CFG_LD: state_d = ST_CFG_B;
      ST_CFG_B:  state_d = ST_IDLE;
      ST_IDLE: begin
        if (arb_any) begin
          take    = 1'b1;
          id_en   = 1'b1;
          idx_d   = '0;
          idx_en  = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (cur_byte == '0) begin
          state_d = ST_IDLE;
        end else if (tx_ready_i) begin
          data_en = 1'b1;
          state_d = ST_PUT;
        end
      end
      ST_PUT: begin
        if (tx_ready_i) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        idx_d   = idx_q + 1'b1;
        idx_en  = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = ST_URST;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_URST;
      idx_q   <= '0;
      id_q    <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx_q  <= idx_d;
      if (id_en)   id_q   <= arb_id;
      if (data_en) data_q <= cur_byte;
    end
  end

  // outputs
  always_comb begin
    case (state_q)
      ST_URST:             ctrl_data_o = '0;
      ST_CFG_A, ST_CFG_LD: ctrl_data_o = CFG_A;
      default:             ctrl_data_o = CFG_B;
    endcase
  end

  assign uart_rst_o = (state_q == ST_URST);
  assign ctrl_ld_o  = (state_q == ST_CFG_LD);
  assign tx_data_o  = data_q;
  assign tx_load_o  = (state_q == ST_LOAD);
  assign busy_o     = (state_q == ST_FETCH) || (state_q == ST_PUT) || (state_q == ST_LOAD);
  assign done_o     = (state_q == ST_FETCH) && (cur_byte == '0);

  // R2: control load sees CFG_A set up a cycle ahead
  a_r2_ctrl_setup: assert property (@(posedge clk) disable iff (!rst_s)
    ctrl_ld_o |-> (ctrl_data_o == CFG_A) && ($past(ctrl_data_o) == CFG_A));
  // R4: data is stable on the load cycle
  a_r4_data_setup: assert property (@(posedge clk) disable iff (!rst_s)
    tx_load_o |-> $stable(tx_data_o));
  // R5: no back-to-back loads
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_s)
    tx_load_o |=> !tx_load_o);
  // R7: transmitter was ready before a load
  a_r7_ready_seen: assert property (@(posedge clk) disable iff (!rst_s)
    tx_load_o |-> $past(tx_ready_i));
  // R6: terminator never loaded
  a_r6_no_zero_load: assert property (@(posedge clk) disable iff (!rst_s)
    tx_load_o |-> (tx_data_o != 8'h00));
  // R9: done ends the busy window
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |-> busy_o ##1 (!busy_o && !done_o));
endmodule

// File: tb/test_status_msg_seq.sv
module test_status_msg_seq;
  localparam time CLK_P = 10ns;
  localparam logic [7:0] CFG_A = 8'h36;
  localparam logic [7:0] CFG_B = 8'h03;
  localparam int BUSY_CYC = 4;
  localparam logic [8:0] DONE_MARK = 9'h100;

  logic clk = 1'b0;
  logic rst_n, tx_ready, stall;
  logic [3:0] req;
  logic uart_rst, ctrl_ld, tx_load, busy, done;
  logic [7:0] ctrl_data, tx_data;
  int checks = 0, fails = 0, cnt = 0, stall_loads = 0;
  logic [8:0] expq[$];
  logic prev_load = 1'b0, prev_ready = 1'b0, prev_done = 1'b0;
  logic [7:0] prev_data = '0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  status_msg_seq #(.CFG_A(CFG_A), .CFG_B(CFG_B)) i_status_msg_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tx_ready_i(tx_ready),
    .uart_rst_o(uart_rst), .ctrl_data_o(ctrl_data), .ctrl_ld_o(ctrl_ld),
    .tx_data_o(tx_data), .tx_load_o(tx_load), .busy_o(busy), .done_o(done));

  // transmitter model: busy for BUSY_CYC cycles after each load
  always_ff @(posedge clk) begin
    if (tx_load) cnt <= BUSY_CYC;
    else if (cnt > 0) cnt <= cnt - 1;
  end
  assign tx_ready = (cnt == 0) && !stall;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic string msg_text(input int id);
    case (id)
      0: return "PASS";
      1: return "RESET";
      2: return "FAIL";
      default: return "";
    endcase
  endfunction

  // driver side: push expected bytes of a message (R3, R6)
  task automatic push_msg(input int id);
    string s = msg_text(id);
    for (int i = 0; i < s.len(); i++) expq.push_back({1'b0, s[i]});
    expq.push_back(9'h00D);
    expq.push_back(9'h00A);
    expq.push_back(DONE_MARK);
  endtask

  task automatic pulse_req(input logic [3:0] r);
    @(posedge clk); #1 req = r;
    @(posedge clk); #1 req = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (expq.size() == 0 && !busy) break;
    end
    check(expq.size() == 0, "R3 queue drained", expq.size(), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (tx_load) begin
        logic [8:0] e;
        check(tx_data == prev_data, "R4 data setup", tx_data, prev_data);
        check(!prev_load, "R5 back-to-back", 1, 0);
        check(prev_ready, "R7 load without ready", 0, 1);
        if (stall && prev_ready == 1'b0) stall_loads++;
        e = (expq.size() > 0) ? expq.pop_front() : 9'h1FF;
        check(e == {1'b0, tx_data}, "R3/R6 byte", tx_data, e);
      end
      if (done) begin
        logic [8:0] e;
        e = (expq.size() > 0) ? expq.pop_front() : 9'h1FF;
        check(e == DONE_MARK, "R9 done position", e, DONE_MARK);
        check(busy, "R9 busy at done", busy, 1);
      end
      if (prev_done) check(!busy && !done, "R9 after done", {busy, done}, 0);
    end
    prev_load  = tx_load;
    prev_ready = tx_ready;
    prev_data  = tx_data;
    prev_done  = done;
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; req = '0; stall = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(uart_rst === 1'b1, "R1 uart reset", uart_rst, 1);
    check(tx_load === 1'b0 && ctrl_ld === 1'b0, "R1 no strobes", {tx_load, ctrl_ld}, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(uart_rst === 1'b1 && !tx_load, "R1 after release", uart_rst, 1);
    for (int i = 0; i < 10 && uart_rst; i++) @(negedge clk);
    // R2 configuration order
    check(ctrl_data == CFG_A && !ctrl_ld, "R2 step A", {ctrl_ld, ctrl_data}, {1'b0, CFG_A});
    @(negedge clk);
    check(ctrl_data == CFG_A && ctrl_ld, "R2 ctrl load", {ctrl_ld, ctrl_data}, {1'b1, CFG_A});
    @(negedge clk);
    check(ctrl_data == CFG_B && !ctrl_ld, "R2 step B", {ctrl_ld, ctrl_data}, {1'b0, CFG_B});
    @(negedge clk);
    check(ctrl_data == CFG_B && !busy && !uart_rst, "R2 idle", {busy, ctrl_data}, {1'b0, CFG_B});

    // single message, with busy timing (R3, R9)
    push_msg(0);
    @(posedge clk); #1 req = 4'b0001;
    @(negedge clk);
    check(!busy, "R9 busy before accept", busy, 0);
    @(posedge clk); #1 req = '0;
    @(negedge clk);
    check(busy, "R9 busy after accept", busy, 1);
    wait_idle();

    // simultaneous requests: lowest first (R8)
    push_msg(0); push_msg(2);
    pulse_req(4'b0101);
    wait_idle();

    // requests during a message are latched and ordered (R8)
    push_msg(1); push_msg(2); push_msg(3);
    pulse_req(4'b0010);
    repeat (5) @(posedge clk);
    pulse_req(4'b1000);
    repeat (4) @(posedge clk);
    pulse_req(4'b0100);
    wait_idle();

    // empty text sends only CR LF (R6)
    push_msg(3);
    pulse_req(4'b1000);
    wait_idle();

    // stalled transmitter: no load while not ready (R7)
    push_msg(1);
    pulse_req(4'b0010);
    repeat (8) @(posedge clk);
    #1 stall = 1'b1;
    @(negedge clk);
    stall_loads = 0;
    repeat (25) @(negedge clk);
    check(stall_loads == 0, "R7 loads during stall", stall_loads, 0);
    check(busy, "R7 still busy during stall", busy, 1);
    @(posedge clk); #1 stall = 1'b0;
    wait_idle();

    repeat (5) @(negedge clk);
    check(!busy && !tx_load, "R9 final idle", {busy, tx_load}, 0);
    report();
  end
endmodule